// File: doc/BRIEF.md
# Dual-Edge Self-Checking Cipher Column Round

This block computes one cipher round on a single 32-bit column and checks its own answer by computing it twice on the same logic. The round takes the four bytes of the column through the byte substitution (multiplicative inverse in GF(2^8) under the polynomial 0x11B, then the affine map with constant 0x63). It then mixes the column and adds a 32-bit key word.

The datapath has two register classes. The input-copy and result registers capture on the rising clock edge. The register between the substitution layer and the mixing layer captures on the falling edge. A pass through the round therefore takes one clock cycle instead of two. The freed cycle is used to run the round again from a second stored copy of the input word. The second result is compared with the first, which is held in a register. The result is released only if the two agree. A mismatch raises a sticky error flag, which stays set until a synchronous clear.

A fault mask input lets a test flip chosen bits of the substitution-layer output during only the first pass or only the second pass. This shows that a transient fault on one pass is caught.

Top module: `dcr_round_unit`

## Requirements
- R1: When both passes agree, `result_o` equals MixColumn(SubBytes(state)) XOR key. Row r of the column is bits [8r+7:8r]. The mix for output row r is 2·a[r] ^ 3·a[r+1] ^ a[r+2] ^ a[r+3], with indices mod 4, multiplication in GF(2^8) mod 0x11B.
- R2: Each byte substitution is the GF(2^8) inverse (0 maps to 0), followed by the affine transform with constant 0x63. For example, 0x00 gives 0x63 and 0x53 gives 0xED.
- R3: A start is accepted on a rising edge when the unit is idle. `busy_o` is high for the next two cycles. `done_o` is high for exactly one cycle, in the cycle that follows the second rising edge after acceptance, and `busy_o` is low in that cycle.
- R4: `state_i` and `key_i` are sampled only on the accepting edge. Both passes use that stored word, so later changes of the inputs do not affect the result.
- R5: If the two pass results differ, `done_o` stays low, `result_o` keeps its previous value, and `err_o` goes high at the compare edge.
- R6: When `flt_mask_i` is non-zero, it is XORed into the substitution-layer output during one pass: the first pass when `flt_pass_i` is 0, the second pass when it is 1. A zero mask injects nothing.
- R7: `err_o` stays high until `err_clr_i` is high at a rising edge. That edge clears it, unless R8 applies.
- R8: When a mismatch verdict and `err_clr_i` fall on the same edge, `err_o` stays set.
- R9: A start raised while `busy_o` is high is ignored. It does not change the result, does not restart the round, and does not produce an extra `done_o`.
- R10: While `rst` is high at a rising edge, `busy_o`, `done_o` and `err_o` go low and `result_o` goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used inside |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request for one checked round |
| state_i | input | 32 | Column word to process |
| key_i | input | 32 | Round-key word |
| flt_mask_i | input | 32 | Bits to flip on the substitution-layer output (test) |
| flt_pass_i | input | 1 | Pass that receives the flip: 0 first, 1 second |
| err_clr_i | input | 1 | Synchronous clear of the error flag |
| result_o | output | 32 | Last agreed round result |
| done_o | output | 1 | One-cycle pulse when a checked result is released |
| busy_o | output | 1 | Round and its recomputation in flight |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
Two events can land on one rising edge: the compare verdict of a round and the synchronous clear of the error flag. The bench raises the clear so that it is sampled on exactly the compare edge. It does this once for a round with a single-pass fault, where the flag must stay set. It does it once for a clean round, where the flag must drop while the done pulse appears. A behavioural model, updated on every rising edge, predicts busy, done, error and result. The bench compares the design with the model at every falling edge.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int COL_BYTES = 4;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = COL_BYTES * BYTE_W;

    localparam logic [BYTE_W-1:0] GF_RED    = 8'h1B;
    localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;
    localparam logic [BYTE_W-1:0] INV_EXP   = 8'hFE;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef struct packed {
        word_t copy_a;
        word_t copy_b;
        word_t key;
    } job_t;

    // multiply by x modulo the field polynomial
    function automatic byte_t xt(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? GF_RED : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xt(x);
        end
        return acc;
    endfunction

    // inverse as a^254 by square and multiply; zero maps to zero
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        byte_t base;
        r    = 8'h01;
        base = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (INV_EXP[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    function automatic byte_t rotl1(input byte_t a);
        return {a[6:0], a[7]};
    endfunction

    function automatic byte_t sbox_byte(input byte_t a);
        byte_t v;
        byte_t r1;
        byte_t r2;
        byte_t r3;
        byte_t r4;
        v  = gf_inv(a);
        r1 = rotl1(v);
        r2 = rotl1(r1);
        r3 = rotl1(r2);
        r4 = rotl1(r3);
        return v ^ r1 ^ r2 ^ r3 ^ r4 ^ AFF_CONST;
    endfunction

    function automatic word_t mix_col(input word_t w);
        byte_t a0, a1, a2, a3;
        byte_t r0, r1, r2, r3;
        a0 = w[7:0];
        a1 = w[15:8];
        a2 = w[23:16];
        a3 = w[31:24];
        r0 = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        r1 = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        r2 = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        r3 = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        return {r3, r2, r1, r0};
    endfunction

endpackage

// File: rtl/rc_sub_layer.sv
module rc_sub_layer
    import dcr_pkg::*;
#(
    parameter int NB = COL_BYTES
) (
    input  logic [NB*BYTE_W-1:0] din,
    output logic [NB*BYTE_W-1:0] dout
);

    for (genvar g = 0; g < NB; g++) begin : g_box
        assign dout[g*BYTE_W +: BYTE_W] = sbox_byte(din[g*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/rc_mix_key.sv
module rc_mix_key
    import dcr_pkg::*;
(
    input  word_t mid,
    input  word_t key,
    output word_t res
);

    assign res = mix_col(mid) ^ key;

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import dcr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    output phase_e phase,
    output logic   accept,
    output logic   busy
);

    phase_e ph_q;

    assign accept = start_i && (ph_q == PH_IDLE);
    assign busy   = (ph_q != PH_IDLE);
    assign phase  = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE:   if (accept) ph_q <= PH_FIRST;
                PH_FIRST:  ph_q <= PH_SECOND;
                PH_SECOND: ph_q <= PH_IDLE;
                default:   ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dcr_round_unit.sv
module dcr_round_unit
    import dcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] state_i,
    input  logic [31:0] key_i,
    input  logic [31:0] flt_mask_i,
    input  logic        flt_pass_i,
    input  logic        err_clr_i,
    output logic [31:0] result_o,
    output logic        done_o,
    output logic        busy_o,
    output logic        err_o
);

    phase_e ph;
    logic   accept;
    logic   busy;
    job_t   job_q;
    word_t  sel_w;
    word_t  sub_w;
    word_t  inj_w;
    word_t  mid_q;
    word_t  res_w;
    word_t  hold_q;
    word_t  result_q;
    logic   done_q;
    logic   err_q;
    logic   pass_now;
    logic   mismatch;

    rc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .phase   (ph),
        .accept  (accept),
        .busy    (busy)
    );

    // rising-edge class: two copies of the input plus the key
    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
        end else if (accept) begin
            job_q <= '{copy_a: state_i, copy_b: state_i, key: key_i};
        end
    end

    assign pass_now = (ph == PH_SECOND);
    assign sel_w    = pass_now ? job_q.copy_b : job_q.copy_a;

    rc_sub_layer #(.NB(COL_BYTES)) u_sub (
        .din  (sel_w),
        .dout (sub_w)
    );

    assign inj_w = (busy && (flt_pass_i == pass_now)) ? flt_mask_i : '0;

    // falling-edge class: substitution output
    always_ff @(negedge clk) begin
        if (rst) begin
            mid_q <= '0;
        end else begin
            mid_q <= sub_w ^ inj_w;
        end
    end

    rc_mix_key u_mix (
        .mid (mid_q),
        .key (job_q.key),
        .res (res_w)
    );

    assign mismatch = pass_now && (res_w != hold_q);

    // rising-edge class: first result, compare, release
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ph == PH_FIRST) hold_q <= res_w;
            if (pass_now && !mismatch) begin
                result_q <= res_w;
                done_q   <= 1'b1;
            end
            if (mismatch) begin
                err_q <= 1'b1;
            end else if (err_clr_i) begin
                err_q <= 1'b0;
            end
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;
    assign busy_o   = busy;
    assign err_o    = err_q;

endmodule

// File: rtl/dcr_round_unit_chk.sv
module dcr_round_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        err_clr_i,
    input logic [31:0] result_o,
    input logic        done_o,
    input logic        busy_o,
    input logic        err_o
);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> busy_o);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R5
    result_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R5
    err_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> !done_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && !err_clr_i) |=> err_o);

endmodule

bind dcr_round_unit dcr_round_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .err_clr_i (err_clr_i),
    .result_o  (result_o),
    .done_o    (done_o),
    .busy_o    (busy_o),
    .err_o     (err_o)
);

// File: tb/dcr_round_unit_test.sv
module dcr_round_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] state_i = '0;
    logic [31:0] key_i = '0;
    logic [31:0] flt_mask_i = '0;
    logic        flt_pass_i = 1'b0;
    logic        err_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        done_o;
    logic        busy_o;
    logic        err_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcr_round_unit uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .state_i    (state_i),
        .key_i      (key_i),
        .flt_mask_i (flt_mask_i),
        .flt_pass_i (flt_pass_i),
        .err_clr_i  (err_clr_i),
        .result_o   (result_o),
        .done_o     (done_o),
        .busy_o     (busy_o),
        .err_o      (err_o)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        int p = 0;
        int aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = aa << 1;
            if (aa > 255) aa = aa ^ 'h11B;
        end
        return p[7:0];
    endfunction

    function automatic logic [7:0] b_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        logic [7:0] o;
        logic [7:0] c = 8'h63;
        for (int k = 1; k < 256; k++) begin
            if (a != 0 && b_mul(a, k[7:0]) == 8'h01) inv = k[7:0];
        end
        for (int i = 0; i < 8; i++) begin
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ c[i];
        end
        return o;
    endfunction

    function automatic logic [31:0] ref_round(input logic [31:0] s,
                                              input logic [31:0] k,
                                              input logic [31:0] m);
        logic [7:0]  a [4];
        logic [31:0] t;
        logic [31:0] o;
        for (int r = 0; r < 4; r++) t[r*8 +: 8] = b_sbox(s[r*8 +: 8]);
        t = t ^ m;
        for (int r = 0; r < 4; r++) a[r] = t[r*8 +: 8];
        for (int r = 0; r < 4; r++) begin
            o[r*8 +: 8] = b_mul(8'h02, a[r]) ^ b_mul(8'h03, a[(r+1)%4])
                        ^ a[(r+2)%4] ^ a[(r+3)%4];
        end
        return o ^ k;
    endfunction

    int          m_cnt = 0;
    logic [31:0] m_s = '0, m_k = '0, m_m = '0;
    logic        m_p = 1'b0;
    logic        e_busy = 1'b0, e_done = 1'b0, e_err = 1'b0;
    logic [31:0] e_res = '0;
    logic        m_live = 1'b0;

    always @(posedge clk) begin
        logic [31:0] r0;
        logic [31:0] r1;
        logic        bad;
        if (rst) begin
            m_cnt = 0; e_busy = 0; e_done = 0; e_err = 0; e_res = '0;
            m_live = 1'b1;
        end else begin
            bad = 1'b0;
            e_done = 1'b0;
            if (m_cnt == 1) begin
                r0 = ref_round(m_s, m_k, m_p ? 32'h0 : m_m);
                r1 = ref_round(m_s, m_k, m_p ? m_m : 32'h0);
                if (r0 == r1) begin
                    e_done = 1'b1;
                    e_res  = r1;
                end else begin
                    bad = 1'b1;
                end
            end
            if (bad) e_err = 1'b1;
            else if (err_clr_i) e_err = 1'b0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end else if (start_i) begin
                m_s = state_i; m_k = key_i; m_m = flt_mask_i; m_p = flt_pass_i;
                m_cnt = 2;
            end
            e_busy = (m_cnt > 0);
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model (R3, R5, R7)
    always @(negedge clk) begin
        if (m_live && !rst) begin
            chk(busy_o == e_busy, "R3 busy", {31'b0, busy_o}, {31'b0, e_busy});
            chk(done_o == e_done, "R3/R5 done", {31'b0, done_o}, {31'b0, e_done});
            chk(err_o == e_err, "R7/R8 err", {31'b0, err_o}, {31'b0, e_err});
            chk(result_o == e_res, "R1/R5 result", result_o, e_res);
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        summary();
        $finish;
    end

    // run one round; returns at the falling edge after the compare edge
    task automatic do_round(input logic [31:0] s, input logic [31:0] k,
                            input logic [31:0] m, input logic p,
                            input bit clr_at_cmp, input bit extra_start);
        @(negedge clk);
        start_i = 1'b1; state_i = s; key_i = k; flt_mask_i = m; flt_pass_i = p;
        @(negedge clk);
        start_i = 1'b0;
        state_i = ~s;
        key_i   = ~k;
        if (extra_start) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (clr_at_cmp) err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
    endtask

    initial begin
        logic [31:0] prev;
        logic [31:0] s;
        logic [31:0] k;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R10 flags",
            {29'b0, busy_o, done_o, err_o}, 32'h0);
        chk(result_o == 0, "R10 result", result_o, 32'h0);
        rst = 1'b0;

        // R2 known substitution values
        do_round(32'h0, 32'h0, 32'h0, 1'b0, 0, 0);
        chk(done_o == 1, "R2 done", {31'b0, done_o}, 32'h1);
        chk(result_o == 32'h63636363, "R2 sbox(00)", result_o, 32'h63636363);
        do_round(32'h53535353, 32'h0, 32'h0, 1'b0, 0, 0);
        chk(result_o == 32'hEDEDEDED, "R2 sbox(53)", result_o, 32'hEDEDEDED);

        // R1 / R4 several patterns, inputs changed after acceptance
        s = 32'h1234ABCD; k = 32'h0F1E2D3C;
        for (int i = 0; i < 6; i++) begin
            do_round(s, k, 32'h0, i[0], 0, 0);
            chk(done_o == 1, "R1 done", {31'b0, done_o}, 32'h1);
            chk(result_o == ref_round(s, k, 32'h0), "R1/R4 value",
                result_o, ref_round(s, k, 32'h0));
            s = s * 32'd1103515245 + 32'd12345;
            k = {k[30:0], k[31]} ^ s;
        end
        do_round(32'hFFFFFFFF, 32'hA5A5A5A5, 32'h0, 1'b1, 0, 0);
        chk(result_o == ref_round(32'hFFFFFFFF, 32'hA5A5A5A5, 0), "R1 ones",
            result_o, ref_round(32'hFFFFFFFF, 32'hA5A5A5A5, 0));
        chk(err_o == 0, "R6 zero mask no error", {31'b0, err_o}, 32'h0);

        // R5 / R6 fault on first pass
        prev = result_o;
        do_round(32'hCAFEF00D, 32'h01020304, 32'h00000010, 1'b0, 0, 0);
        chk(err_o == 1, "R6 first-pass fault err", {31'b0, err_o}, 32'h1);
        chk(done_o == 0, "R5 no done on mismatch", {31'b0, done_o}, 32'h0);
        chk(result_o == prev, "R5 result kept", result_o, prev);
        repeat (3) @(negedge clk);
        chk(err_o == 1, "R7 err sticky", {31'b0, err_o}, 32'h1);
        clear_err();
        chk(err_o == 0, "R7 clear", {31'b0, err_o}, 32'h0);

        // R6 fault on second pass
        do_round(32'h89ABCDEF, 32'h11111111, 32'h80000000, 1'b1, 0, 0);
        chk(err_o == 1, "R6 second-pass fault err", {31'b0, err_o}, 32'h1);
        clear_err();

        // R9 start while busy ignored
        do_round(32'h00FF00FF, 32'h13572468, 32'h0, 1'b0, 0, 1);
        chk(result_o == ref_round(32'h00FF00FF, 32'h13572468, 0), "R9 first kept",
            result_o, ref_round(32'h00FF00FF, 32'h13572468, 0));
        @(negedge clk);
        chk(done_o == 0 && busy_o == 0, "R9 no restart",
            {30'b0, busy_o, done_o}, 32'h0);

        // R8 clear and mismatch verdict on the same edge
        do_round(32'h31415926, 32'h27182818, 32'h00000100, 1'b0, 1, 0);
        chk(err_o == 1, "R8 set wins over clear", {31'b0, err_o}, 32'h1);
        // clear coinciding with a good verdict
        do_round(32'h31415926, 32'h27182818, 32'h0, 1'b0, 1, 0);
        chk(err_o == 0, "R7 clear with good verdict", {31'b0, err_o}, 32'h0);
        chk(done_o == 1, "R3 done with clear", {31'b0, done_o}, 32'h1);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule